// File: doc/BRIEF.md
# Packed Vector Uniform Loader

This block receives a stream of 32-bit configuration writes and assembles them into four-component vectors of 24-bit floating-point values. Each complete vector is committed to a uniform memory that holds 96 vectors. A mode input selects how the words are read.

In single-precision mode, four consecutive words each carry one IEEE single-precision value. Each value is narrowed to the 24-bit format. In packed mode, three consecutive words carry four 24-bit values laid end to end.

Software first loads a start index. It then streams words, and each completed vector lands at the current index. The index then advances, so a run of vectors fills consecutive entries. A commit aimed past the end of the memory writes nothing and raises a one-cycle error pulse. A synchronous read port exposes any stored vector.

Top module: `vul_loader`

## Requirements
- R1: While `rst` is high and after its release, the word counter and target index are zero, `err_pulse` is low, and no commit is pending.
- R2: With `mode_f32`=1, a vector is committed after the fourth accepted word. Word number i (0 = first) is converted and stored as component 3-i, so the first word becomes w and the fourth becomes x.
- R3: Single-to-24-bit conversion works as follows. The 24-bit layout is sign in bit 23, a 7-bit exponent with bias 63 in bits 22:16, and the mantissa in bits 15:0. The sign is kept. The result depends on the input exponent e:
  - e from 65 to 191: the exponent becomes e-64 and the mantissa is bits 22:7 of the input.
  - e of 64 or below (zero included): the result is signed zero.
  - e of 192 or above: the result is the signed maximum, with exponent 7F and mantissa FFFF.
- R4: With `mode_f32`=0, a vector is committed after the third accepted word (w0, w1, w2 in arrival order):
  - w = w0[31:8]
  - z = {w0[7:0], w1[31:16]}
  - y = {w1[15:0], w2[31:24]}
  - x = w2[23:0]
- R5: A vector whose words have not all arrived changes no memory entry.
- R6: Each in-range commit writes the entry at the target index, and the index then increases by one.
- R7: A commit with the target index at 96 or above writes nothing and leaves the index unchanged. `err_pulse` is high for exactly one cycle, the cycle after the commit cycle.
- R8: A cycle with `idx_load` high sets the target index to `idx_value` and clears the word counter. It discards staged words, any write in the same cycle, and any commit in that cycle.
- R9: `rd_data` is the entry at `rd_addr` registered one cycle after the address is presented, packed as {x, y, z, w} with x in bits 95:72 and w in bits 23:0.
- R10: The final word's clock edge launches the commit, and the memory is written on the next edge. The word counter returns to zero, and words for the next vector may follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data word strobe |
| wr_data | input | 32 | Data word |
| mode_f32 | input | 1 | 1: four single-precision words per vector; 0: three packed words |
| idx_load | input | 1 | Load the target index and clear staging |
| idx_value | input | 7 | New target index |
| rd_addr | input | 7 | Read address into the vector memory |
| rd_data | output | 96 | Registered vector {x, y, z, w} |
| err_pulse | output | 1 | One-cycle pulse on an out-of-range commit |

## Verification
The bench builds the block with its default depth of 96 entries. With that depth, the last valid entry (95) and the first invalid index (96) are both reachable with a few loads and commits. It steps across the single-precision exponent window (65 and 191) and into both saturation regions. It also checks the packed slicing with byte patterns that reveal any shifted or swapped field. It interleaves partial vectors with index loads so that a stale staged word would show up in the next stored vector.

// File: rtl/vul_pkg.sv
package vul_pkg;
  localparam int WORD_W = 32;
  localparam int COMP_W = 24;
  localparam int VEC_W  = 4 * COMP_W;

  // single precision -> 24-bit float (1/7/16, bias 63), truncating
  function automatic logic [COMP_W-1:0] f32_to_f24(input logic [WORD_W-1:0] v);
    logic       s;
    logic [7:0] e;
    logic [7:0] e_new;
    s = v[31];
    e = v[30:23];
    e_new = e - 8'd64;
    if (e <= 8'd64)
      f32_to_f24 = {s, 23'd0};
    else if (e >= 8'd192)
      f32_to_f24 = {s, 7'h7f, 16'hffff};
    else
      f32_to_f24 = {s, e_new[6:0], v[22:7]};
  endfunction
endpackage

// File: rtl/vul_stage.sv
module vul_stage
  import vul_pkg::*;
#(
  parameter int NWORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     mode_f32,
  output logic [1:0]               cnt_o,
  output logic                     commit_v,
  output logic                     commit_f32,
  output logic [NWORDS*WORD_W-1:0] words
);
  logic [1:0]        cnt_q;
  logic [WORD_W-1:0] stg_q [NWORDS];
  logic              last_word;

  assign last_word = mode_f32 ? (cnt_q == 2'd3) : (cnt_q >= 2'd2);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q      <= '0;
      commit_v   <= 1'b0;
      commit_f32 <= 1'b0;
    end else begin
      commit_v <= wr_en && last_word;
      if (wr_en) begin
        if (last_word) begin
          cnt_q      <= '0;
          commit_f32 <= mode_f32;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_stg
    always_ff @(posedge clk) begin
      if (wr_en && !clr && (cnt_q == 2'(i)))
        stg_q[i] <= wr_data;
    end
    assign words[i*WORD_W +: WORD_W] = stg_q[i];
  end
endmodule

// File: rtl/vul_unpack.sv
module vul_unpack
  import vul_pkg::*;
(
  input  logic [4*WORD_W-1:0] words,
  input  logic                f32,
  output logic [VEC_W-1:0]    vec
);
  logic [COMP_W-1:0] cv [4];
  logic [WORD_W-1:0] w0, w1, w2;
  logic [VEC_W-1:0]  vec_f, vec_p;

  for (genvar i = 0; i < 4; i++) begin : g_cvt
    assign cv[i] = f32_to_f24(words[i*WORD_W +: WORD_W]);
  end

  assign w0 = words[0*WORD_W +: WORD_W];
  assign w1 = words[1*WORD_W +: WORD_W];
  assign w2 = words[2*WORD_W +: WORD_W];

  // first word -> w (low lane), last word -> x (high lane)
  assign vec_f = {cv[3], cv[2], cv[1], cv[0]};
  assign vec_p = {w2[23:0], w1[15:0], w2[31:24], w0[7:0], w1[31:16], w0[31:8]};
  assign vec   = f32 ? vec_f : vec_p;
endmodule

// File: rtl/vul_mem.sv
module vul_mem #(
  parameter int DEPTH = 96,
  parameter int AW    = 7,
  parameter int DW    = 96
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vul_loader.sv
module vul_loader
  import vul_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int IDXW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              mode_f32,
  input  logic              idx_load,
  input  logic [IDXW-1:0]   idx_value,
  input  logic [IDXW-1:0]   rd_addr,
  output logic [VEC_W-1:0]  rd_data,
  output logic              err_pulse
);
  localparam logic [IDXW-1:0] LIMIT = IDXW'(DEPTH);

  logic [1:0]          cnt;
  logic                commit_v;
  logic                commit_f32;
  logic [4*WORD_W-1:0] words;
  logic [VEC_W-1:0]    vec;
  logic [IDXW-1:0]     idx_q;
  logic                commit_go;
  logic                in_range;
  logic                mem_we;

  vul_stage #(.NWORDS(4)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .clr       (idx_load),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mode_f32  (mode_f32),
    .cnt_o     (cnt),
    .commit_v  (commit_v),
    .commit_f32(commit_f32),
    .words     (words)
  );

  vul_unpack u_unpack (
    .words(words),
    .f32  (commit_f32),
    .vec  (vec)
  );

  assign commit_go = commit_v && !idx_load;
  assign in_range  = idx_q < LIMIT;
  assign mem_we    = commit_go && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= commit_go && !in_range;
      if (idx_load)
        idx_q <= idx_value;
      else if (mem_we)
        idx_q <= idx_q + IDXW'(1);
    end
  end

  vul_mem #(.DEPTH(DEPTH), .AW(IDXW), .DW(VEC_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(idx_q),
    .wdata(vec),
    .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/vul_loader_chk.sv
module vul_loader_chk #(
  parameter int DEPTH = 96,
  parameter int IDXW  = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            idx_load,
  input logic [IDXW-1:0] idx_value,
  input logic [1:0]      cnt,
  input logic            commit_v,
  input logic [IDXW-1:0] idx_q,
  input logic            err_pulse
);
  localparam logic [IDXW-1:0] LIMIT = IDXW'(DEPTH);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cnt == 2'd0) && !commit_v && !err_pulse && (idx_q == '0));

  p_commit_gap_r10: assert property (@(posedge clk) disable iff (rst)
    commit_v |=> !commit_v);

  p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
    (commit_v && !idx_load && (idx_q < LIMIT)) |=> (idx_q == $past(idx_q) + IDXW'(1)));

  p_oor_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_v && !idx_load && (idx_q >= LIMIT)) |=> (err_pulse && $stable(idx_q)));

  p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

  p_load_clears_r8: assert property (@(posedge clk) disable iff (rst)
    idx_load |=> (cnt == 2'd0) && !commit_v && (idx_q == $past(idx_value)));
endmodule

bind vul_loader vul_loader_chk #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .idx_load (idx_load),
  .idx_value(idx_value),
  .cnt      (cnt),
  .commit_v (commit_v),
  .idx_q    (idx_q),
  .err_pulse(err_pulse)
);

// File: tb/vul_loader_tb.sv
module vul_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        mode_f32 = 1'b0;
  logic        idx_load = 1'b0;
  logic [6:0]  idx_value = '0;
  logic [6:0]  rd_addr = '0;
  logic [95:0] rd_data;
  logic        err_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vul_loader u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .mode_f32(mode_f32),
    .idx_load(idx_load), .idx_value(idx_value), .rd_addr(rd_addr),
    .rd_data(rd_data), .err_pulse(err_pulse)
  );

  // bench model of the narrowing rule
  function automatic logic [23:0] ref_cvt(input logic [31:0] v);
    int e;
    e = int'(v[30:23]);
    if (e < 65)       return {v[31], 23'd0};
    else if (e > 191) return {v[31], 23'h7fffff};
    else              return {v[31], 7'(e - 64), v[22:7]};
  endfunction

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_idx(input logic [6:0] v);
    @(negedge clk); idx_load = 1'b1; idx_value = v;
    @(negedge clk); idx_load = 1'b0;
  endtask

  task automatic put(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [95:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset();
    check("R1 err", {95'd0, err_pulse}, 96'd0);
    // first commit lands at index 0
    mode_f32 = 1'b0;
    put(32'h01020304); put(32'h05060708); put(32'h090a0b0c);
    repeat (2) @(negedge clk);
    begin
      logic [95:0] d;
      rd(7'd0, d);
      check("R1 index0", d, {24'h0a0b0c, 24'h070809, 24'h040506, 24'h010203});
    end
  endtask

  task automatic t_single();
    logic [95:0] d;
    logic [31:0] w [4];
    mode_f32 = 1'b1;
    load_idx(7'd20);
    w[0] = 32'h3F800000; w[1] = 32'h40000000; w[2] = 32'hBFC00000; w[3] = 32'h00000000;
    foreach (w[i]) put(w[i]);
    repeat (2) @(negedge clk);
    rd(7'd20, d);
    check("R2 order", d, {24'h000000, 24'hBF8000, 24'h400000, 24'h3F0000});
    // R3 window edges and saturation, back to back into index 21
    w[0] = 32'h7F000000; w[1] = 32'h20000000; w[2] = 32'h80000000; w[3] = 32'h3FFFFFFF;
    foreach (w[i]) put(w[i]);
    repeat (2) @(negedge clk);
    rd(7'd21, d);
    check("R3 sat", d, {ref_cvt(w[3]), ref_cvt(w[2]), ref_cvt(w[1]), ref_cvt(w[0])});
    check("R3 sat literal", d, {24'h3FFFFF, 24'h800000, 24'h000000, 24'h7FFFFF});
    w[0] = 32'h5F800000; w[1] = 32'h20800000; w[2] = 32'hDF812345; w[3] = 32'h60000000;
    foreach (w[i]) put(w[i]);
    repeat (2) @(negedge clk);
    rd(7'd22, d);
    check("R3 edges R6", d, {24'h7FFFFF, 24'hFF0246, 24'h010000, 24'h7F0000});
  endtask

  task automatic t_packed();
    logic [95:0] d;
    mode_f32 = 1'b0;
    load_idx(7'd40);
    put(32'h11223344); put(32'h55667788); put(32'h99AABBCC);
    put(32'hDEADBEEF); put(32'h01234567); put(32'h89ABCDEF);
    repeat (2) @(negedge clk);
    rd(7'd40, d);
    check("R4 slice", d, {24'hAABBCC, 24'h778899, 24'h445566, 24'h112233});
    rd(7'd41, d);
    check("R4 R10 back-to-back", d, {24'hABCDEF, 24'h456789, 24'hEF0123, 24'hDEADBE});
  endtask

  task automatic t_partial();
    logic [95:0] d;
    mode_f32 = 1'b0;
    load_idx(7'd10);
    put(32'hAAAAAAAA); put(32'hBBBBBBBB); put(32'hCCCCCCCC);
    repeat (2) @(negedge clk);
    put(32'h12121212); put(32'h34343434);
    repeat (3) @(negedge clk);
    rd(7'd10, d);
    check("R5 untouched", d, {24'hCCCCCC, 24'hBBBBCC, 24'hAABBBB, 24'hAAAAAA});
    rd(7'd11, d);
    check("R5 no partial commit", d[95:48], 48'hxxxxxxxxxxxx);
    load_idx(7'd10);
    // write dropped in the load cycle
    @(negedge clk); idx_load = 1'b1; idx_value = 7'd10; wr_en = 1'b1; wr_data = 32'h77777777;
    @(negedge clk); idx_load = 1'b0; wr_en = 1'b0;
    put(32'h11223344); put(32'h55667788); put(32'h99AABBCC);
    repeat (2) @(negedge clk);
    rd(7'd10, d);
    check("R8 discard", d, {24'hAABBCC, 24'h778899, 24'h445566, 24'h112233});
  endtask

  task automatic t_range();
    logic [95:0] d;
    mode_f32 = 1'b0;
    load_idx(7'd95);
    put(32'h0000FFFF); put(32'h00000000); put(32'hFF000001);
    @(negedge clk);
    check("R7 no err in range", {95'd0, err_pulse}, 96'd0);
    put(32'h11111111); put(32'h22222222); put(32'h33333333);
    @(negedge clk);
    check("R7 err set", {95'd0, err_pulse}, 96'd1);
    @(negedge clk);
    check("R7 err one cycle", {95'd0, err_pulse}, 96'd0);
    put(32'h44444444); put(32'h55555555); put(32'h66666666);
    @(negedge clk);
    check("R7 index held", {95'd0, err_pulse}, 96'd1);
    rd(7'd95, d);
    check("R7 R9 entry95", d, {24'h000001, 24'h0000FF, 24'hFF0000, 24'h0000FF});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 err in reset", {95'd0, err_pulse}, 96'd0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_packed();
    t_partial();
    t_range();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule